// File: doc/BRIEF.md
# Randomizing Multi-Issue Instruction Dispatcher

This block reads one group of instructions per fetch from an instruction memory. A group holds one slot per execution region. The block sends each valid instruction to the execution region that owns the function unit the instruction names. Each region has its own ready, request and acknowledge signals. A region receives a new instruction only when it reports ready. The program counter moves to the next group once every valid instruction of the current group has been accepted.

As a side-channel countermeasure, a mode input lets the block change the order in which a group's slots are offered. A seedable 16-bit LFSR drives this reordering. The same reordering also decides which of several slots aimed at one region is served first. With the mode off, slots are offered in ascending slot order, so a run is fully predictable. Because the seed can be loaded, a shuffled run can be reproduced.

Top module: `rand_issue_dispatch`

## Requirements
- R1: Reset behaviour. While `rst_n` is low and just after it is released, every `rgn_req` bit is low and `fetch_addr` is 0. The LFSR holds 16'hACE1.
- R2: Group format. `fetch_addr` is the index of the group being fetched. Slot s sits at `fetch_group[s*16 +: 16]`. Bit 15 of a slot is the valid flag, bits 14:12 are the unit number and bits 11:0 are payload. Invalid slots are never issued. A group with no valid slot is skipped.
- R3: Routing. A slot goes to region `UNIT_RGN[unit*RW +: RW]`. By default the region is the unit number modulo NREG. `rgn_data` carries the whole 16-bit word.
- R4: A region's request can rise only at a clock edge where that region's `rgn_rdy` is high.
- R5: A raised request stays high, with stable data, until a rising edge sees both request and acknowledge high. The request is low in the following cycle.
- R6: The program counter goes up by exactly one. It does so only after every valid slot of the group has been acknowledged. No group is fetched while `go` is low.
- R7: With `shuffle_en` low when a group is fetched, slots are offered in ascending slot order. Each region receives its slots in ascending slot order.
- R8: With `shuffle_en` high when a group is fetched, take L as the LFSR value at that fetch. Let rot = L[1:0] and dir = L[2]. Offer position k then holds slot (rot+k) mod 4 if dir is 0, or (rot-k) mod 4 if dir is 1. Slots that compete for one region are served in this offer order.
- R9: The LFSR shifts left once per group fetch, whatever the mode is. The new bit 0 is L[15]^L[13]^L[12]^L[10].
- R10: `seed_we` loads `seed_val` into the LFSR at a rising edge. A zero seed is loaded as 16'h0001.
- R11: Regions work independently. Several regions may complete handshakes at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Allows new groups to be fetched |
| shuffle_en | input | 1 | Selects shuffled offer order, sampled at each fetch |
| seed_we | input | 1 | Loads the LFSR seed |
| seed_val | input | 16 | Seed value |
| fetch_addr | output | AW | Group index presented to instruction memory |
| fetch_group | input | NREG*IW | Group read at `fetch_addr` (combinational memory) |
| rgn_rdy | input | NREG | Region can accept a new instruction |
| rgn_req | output | NREG | Instruction offered to region |
| rgn_data | output | NREG*IW | Instruction word for each region |
| rgn_ack | input | NREG | Region accepts the offered instruction |

## Verification
Two events can fall on one edge: handshakes that several regions complete together, and the clearing of slots that ends a group and moves the program counter. The bench gives each region an acknowledge delay that depends on both the region and the cycle, and it toggles ready per region with a phase offset. This makes simultaneous completions and last-slot completions happen often, and the bench counts how many edges carry more than one handshake. It judges the result in three ways. A per-region scoreboard checks the exact order, which the bench predicts from its own LFSR model. Each program counter step is matched against the total number of instructions expected up to that group. The bench also checks that requests drop after acceptance.

// File: rtl/disp_pkg.sv
package disp_pkg;

  localparam int LFSR_W = 16;
  localparam int MAP_W  = 64;

  // next state of the scrambler: shift left, feedback from bits 15,13,12,10
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // an all-zero state would lock the scrambler
  function automatic logic [LFSR_W-1:0] seed_fix(input logic [LFSR_W-1:0] v);
    return (v == '0) ? {{(LFSR_W-1){1'b0}}, 1'b1} : v;
  endfunction

  // default routing: unit number modulo the region count (power of two)
  function automatic logic [MAP_W-1:0] mod_map(input int nfu, input int rw);
    logic [MAP_W-1:0] m;
    m = '0;
    for (int u = 0; u < nfu; u++)
      for (int b = 0; b < rw; b++)
        if (u * rw + b < MAP_W) m[u*rw+b] = 1'((u >> b) & 1);
    return m;
  endfunction

  // slot offered at position k for a rotation and a direction
  function automatic int offer_slot(input int rot, input int dir, input int k, input int n);
    int r;
    r = rot % n;
    return (dir != 0) ? ((r - k + n) % n) : ((r + k) % n);
  endfunction

endpackage

// File: rtl/disp_lfsr.sv
module disp_lfsr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed_we,
  input  logic [15:0] seed_val,
  input  logic        step,
  output logic [15:0] state
);
  import disp_pkg::*;

  localparam logic [15:0] RESET_STATE = 16'hACE1;

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= RESET_STATE;
    else if (seed_we) state <= seed_fix(seed_val);
    else if (step)    state <= lfsr_next(state);
  end
endmodule

// File: rtl/disp_order.sv
module disp_order #(
  parameter int NREG = 4,
  localparam int RW = $clog2(NREG)
) (
  input  logic [RW:0]        rbits,
  input  logic               shuffle,
  output logic [NREG*RW-1:0] order
);
  import disp_pkg::*;

  for (genvar k = 0; k < NREG; k++) begin : g_pos
    always_comb begin
      if (shuffle)
        order[k*RW +: RW] = RW'(offer_slot(int'(rbits[RW-1:0]), int'(rbits[RW]), k, NREG));
      else
        order[k*RW +: RW] = RW'(k);
    end
  end
endmodule

// File: rtl/disp_port.sv
module disp_port #(
  parameter int NREG = 4,
  parameter int IW   = 16,
  parameter int RGN  = 0,
  localparam int RW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               rdy,
  input  logic               ack,
  input  logic [NREG-1:0]    pending,
  input  logic [NREG*RW-1:0] slot_rgn,
  input  logic [NREG*RW-1:0] order,
  input  logic [NREG*IW-1:0] words,
  output logic               req,
  output logic [IW-1:0]      data,
  output logic [NREG-1:0]    clr
);
  logic          found;
  logic [RW-1:0] pick;
  logic [RW-1:0] s;
  logic [RW-1:0] slot_q;

  // first pending slot of this region in offer order
  always_comb begin
    found = 1'b0;
    pick  = '0;
    s     = '0;
    for (int k = 0; k < NREG; k++) begin
      s = order[k*RW +: RW];
      if (!found && pending[s] && (slot_rgn[int'(s)*RW +: RW] == RW'(RGN))) begin
        found = 1'b1;
        pick  = s;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req    <= 1'b0;
      slot_q <= '0;
      data   <= '0;
    end else if (req) begin
      if (ack) req <= 1'b0;
    end else if (active && rdy && found) begin
      req    <= 1'b1;
      slot_q <= pick;
      data   <= words[int'(pick)*IW +: IW];
    end
  end

  assign clr = (req && ack) ? (NREG'(1) << slot_q) : '0;
endmodule

// File: rtl/rand_issue_dispatch.sv
module rand_issue_dispatch #(
  parameter int NREG = 4,
  parameter int IW   = 16,
  parameter int UW   = 3,
  parameter int AW   = 6,
  parameter logic [63:0] UNIT_RGN = disp_pkg::mod_map(1 << UW, $clog2(NREG))
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               shuffle_en,
  input  logic               seed_we,
  input  logic [15:0]        seed_val,
  output logic [AW-1:0]      fetch_addr,
  input  logic [NREG*IW-1:0] fetch_group,
  input  logic [NREG-1:0]    rgn_rdy,
  output logic [NREG-1:0]    rgn_req,
  output logic [NREG*IW-1:0] rgn_data,
  input  logic [NREG-1:0]    rgn_ack
);
  localparam int RW    = $clog2(NREG);
  localparam int VBIT  = IW - 1;
  localparam int UTOP  = IW - 2;

  function automatic logic [RW-1:0] route(input logic [UW-1:0] u);
    return UNIT_RGN[int'(u)*RW +: RW];
  endfunction

  logic               active;
  logic [AW-1:0]      pc;
  logic [NREG*IW-1:0] words_q;
  logic [NREG-1:0]    pending;
  logic [NREG*RW-1:0] order_q;
  logic [NREG*RW-1:0] order_c;
  logic [NREG*RW-1:0] slot_rgn;
  logic [NREG-1:0]    valid_in;
  logic [NREG-1:0]    clr_m [NREG];
  logic [NREG-1:0]    clr_all;
  logic [15:0]        lfsr;

  // named events
  logic grp_load;
  logic grp_done;
  assign grp_load = !active && go;
  assign grp_done = active && (pending == '0);

  assign fetch_addr = pc;

  always_comb begin
    for (int s = 0; s < NREG; s++) begin
      valid_in[s]            = fetch_group[s*IW + VBIT];
      slot_rgn[s*RW +: RW]   = route(words_q[s*IW + UTOP -: UW]);
    end
  end

  always_comb begin
    clr_all = '0;
    for (int r = 0; r < NREG; r++) clr_all = clr_all | clr_m[r];
  end

  disp_lfsr u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_we  (seed_we),
    .seed_val (seed_val),
    .step     (grp_load),
    .state    (lfsr)
  );

  disp_order #(.NREG(NREG)) u_order (
    .rbits   (lfsr[RW:0]),
    .shuffle (shuffle_en),
    .order   (order_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      pc      <= '0;
      words_q <= '0;
      pending <= '0;
      order_q <= '0;
    end else if (grp_load) begin
      active  <= 1'b1;
      words_q <= fetch_group;
      pending <= valid_in;
      order_q <= order_c;
    end else if (grp_done) begin
      active  <= 1'b0;
      pc      <= pc + 1'b1;
    end else begin
      pending <= pending & ~clr_all;
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_rgn
    disp_port #(.NREG(NREG), .IW(IW), .RGN(r)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .rdy      (rgn_rdy[r]),
      .ack      (rgn_ack[r]),
      .pending  (pending),
      .slot_rgn (slot_rgn),
      .order    (order_q),
      .words    (words_q),
      .req      (rgn_req[r]),
      .data     (rgn_data[r*IW +: IW]),
      .clr      (clr_m[r])
    );
  end
endmodule

// File: rtl/disp_chk.sv
module disp_chk #(
  parameter int NREG = 4,
  parameter int IW   = 16,
  parameter int UW   = 3,
  parameter int AW   = 6,
  parameter logic [63:0] UNIT_RGN = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      fetch_addr,
  input logic [NREG-1:0]    rgn_rdy,
  input logic [NREG-1:0]    rgn_req,
  input logic [NREG*IW-1:0] rgn_data,
  input logic [NREG-1:0]    rgn_ack,
  input logic               grp_done
);
  localparam int RW = $clog2(NREG);

  function automatic logic [RW-1:0] home(input logic [UW-1:0] u);
    return UNIT_RGN[int'(u)*RW +: RW];
  endfunction

  // R6: group index only ever steps by one
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fetch_addr) |-> fetch_addr == $past(fetch_addr) + 1'b1);

  // R6: an offer still waiting blocks the program counter
  a_r6_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rgn_req & ~rgn_ack)) |=> $stable(fetch_addr));

  // R6: group completion only with every port quiet
  a_r6_done: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |-> rgn_req == '0);

  for (genvar r = 0; r < NREG; r++) begin : g_chk
    // R4
    a_r4_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (!rgn_req[r] && !rgn_rdy[r]) |=> !rgn_req[r]);
    // R5
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rgn_req[r] && !rgn_ack[r]) |=> rgn_req[r] && $stable(rgn_data[r*IW +: IW]));
    // R5
    a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rgn_req[r] && rgn_ack[r]) |=> !rgn_req[r]);
    // R2
    a_r2_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_req[r] |-> rgn_data[r*IW + IW - 1]);
    // R3
    a_r3_route: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_req[r] |-> home(rgn_data[r*IW + IW - 2 -: UW]) == RW'(r));
  end
endmodule

bind rand_issue_dispatch disp_chk #(
  .NREG(NREG), .IW(IW), .UW(UW), .AW(AW), .UNIT_RGN(UNIT_RGN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_addr (fetch_addr),
  .rgn_rdy    (rgn_rdy),
  .rgn_req    (rgn_req),
  .rgn_data   (rgn_data),
  .rgn_ack    (rgn_ack),
  .grp_done   (grp_done)
);

// File: tb/rand_issue_dispatch_test.sv
module rand_issue_dispatch_test;
  localparam int NR = 4;
  localparam int IW = 16;
  localparam int AW = 6;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               go, shuffle_en, seed_we;
  logic [15:0]        seed_val;
  logic [AW-1:0]      fetch_addr;
  logic [NR*IW-1:0]   fetch_group;
  logic [NR-1:0]      rgn_rdy, rgn_req, rgn_ack;
  logic [NR*IW-1:0]   rgn_data;

  always #10 clk = ~clk;

  rand_issue_dispatch #(.NREG(NR), .IW(IW), .UW(3), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .shuffle_en(shuffle_en),
    .seed_we(seed_we), .seed_val(seed_val), .fetch_addr(fetch_addr),
    .fetch_group(fetch_group), .rgn_rdy(rgn_rdy), .rgn_req(rgn_req),
    .rgn_data(rgn_data), .rgn_ack(rgn_ack)
  );

  // instruction memory image, computed
  function automatic logic [15:0] mem_word(input int g, input int s);
    int gm, u;
    logic v;
    gm = g % 12;
    if (gm == 9)      v = 1'b0;
    else if (gm == 7) v = 1'b1;
    else              v = ((g + s * 3) % 4) != 1;
    if (gm == 5)      u = (s % 2 != 0) ? 5 : 1;
    else if (gm == 7) u = ((s + g) % 4) + 4 * (s % 2);
    else              u = (g * 5 + s * 3 + g / 4) % 8;
    return {v, 3'(u), 6'(g), 2'(s), 4'h5};
  endfunction

  always_comb
    for (int s = 0; s < NR; s++) fetch_group[s*IW +: IW] = mem_word(int'(fetch_addr), s);

  function automatic logic [15:0] lfsr_adv(input logic [15:0] x);
    return {x[14:0], ^(x & 16'hB400)};
  endfunction

  int          n_cmp = 0, n_bad = 0;
  logic [15:0] model;
  logic [15:0] exp_q [NR][$];
  int          cum [64];
  int          total = 0, popped = 0;
  int          cyc = 0, rdy_mode = 0, multi_hs = 0;
  string       cur_tag = "R7";
  logic [AW-1:0] last_pc = '0;
  logic [NR-1:0] req_prev = '0, rdy_seen = '1;
  int          wcnt [NR];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // scoreboard driver side: predict a group's issues per region
  task automatic plan_group(input int g, input bit sh);
    int rot, dir, s, r;
    logic [15:0] w;
    rot = int'(model[1:0]);
    dir = int'(model[2]);
    for (int k = 0; k < NR; k++) begin
      if (sh) s = (dir != 0) ? ((rot - k + NR) % NR) : ((rot + k) % NR);
      else    s = k;
      w = mem_word(g, s);
      if (w[15]) begin
        r = int'(w[14:12]) % NR;
        exp_q[r].push_back(w);
        total++;
      end
    end
    cum[g] = total;
    model = lfsr_adv(model);
  endtask

  // monitor and region models
  always @(negedge clk) begin
    if (rst_n) begin
      int hs;
      hs = 0;
      cyc++;
      for (int r = 0; r < NR; r++) begin
        if (rgn_ack[r]) begin
          rgn_ack[r] = 1'b0;
          chk(!rgn_req[r], "R5", "request after acceptance", int'(rgn_req[r]), 0);
        end else if (rgn_req[r]) begin
          if (!req_prev[r]) begin
            chk(rdy_seen[r], "R4", "request rose without ready", 0, 1);
            wcnt[r] = (r + cyc) % 3;
          end
          if (wcnt[r] == 0) begin
            if (exp_q[r].size() == 0) begin
              chk(1'b0, "R11", "unexpected issue", int'(rgn_data[r*IW +: IW]), 0);
            end else begin
              logic [15:0] e;
              e = exp_q[r].pop_front();
              chk(rgn_data[r*IW +: IW] == e, {"R3,", cur_tag}, "issued word",
                  int'(rgn_data[r*IW +: IW]), int'(e));
              popped++;
            end
            rgn_ack[r] = 1'b1;
            hs++;
          end else begin
            wcnt[r]--;
          end
        end
        req_prev[r] = rgn_req[r];
        rgn_rdy[r]  = (rdy_mode == 0) ? 1'b1 : (((cyc + r) % 4) != 0);
        rdy_seen[r] = rgn_rdy[r];
      end
      if (hs > 1) multi_hs++;
      if (fetch_addr != last_pc) begin
        chk(fetch_addr == last_pc + 1'b1, "R6", "pc step", int'(fetch_addr), int'(last_pc) + 1);
        chk(popped == cum[int'(last_pc)], "R6", "issued before advance", popped, cum[int'(last_pc)]);
        last_pc = fetch_addr;
      end
    end
  end

  task automatic load_seed(input logic [15:0] v);
    seed_val = v;
    seed_we  = 1'b1;
    @(negedge clk);
    seed_we  = 1'b0;
    model    = (v == 16'h0) ? 16'h0001 : v;
  endtask

  task automatic run_phase(input int n, input bit sh, input int mode, input string tag);
    int st;
    st = int'(fetch_addr);
    cur_tag    = tag;
    rdy_mode   = mode;
    shuffle_en = sh;
    for (int i = 0; i < n; i++) plan_group(st + i, sh);
    go = 1'b1;
    while (fetch_addr != AW'(st + n)) @(negedge clk);
    go = 1'b0;
    repeat (4) @(negedge clk);
    for (int r = 0; r < NR; r++)
      chk(exp_q[r].size() == 0, "R2", "items left unissued", exp_q[r].size(), 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; go = 1'b0; shuffle_en = 1'b0; seed_we = 1'b0; seed_val = '0;
    rgn_ack = '0; rgn_rdy = '1; model = 16'hACE1;
    for (int r = 0; r < NR; r++) wcnt[r] = 0;
    repeat (3) @(negedge clk);
    chk(rgn_req == '0, "R1", "requests in reset", int'(rgn_req), 0);
    chk(fetch_addr == '0, "R1", "pc in reset", int'(fetch_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rgn_req == '0, "R1", "requests after reset", int'(rgn_req), 0);

    run_phase(6, 1'b1, 0, "R1,R8");          // order from the reset LFSR value
    run_phase(12, 1'b0, 0, "R7");            // plain ascending order
    load_seed(16'h1D2B);
    run_phase(12, 1'b1, 1, "R8,R4");         // shuffled with gated ready

    for (int i = 0; i < 12; i++) begin       // go low: nothing fetched
      @(negedge clk);
      chk(fetch_addr == last_pc, "R6", "pc moved while go low", int'(fetch_addr), int'(last_pc));
      chk(rgn_req == '0, "R6", "issue while go low", int'(rgn_req), 0);
    end

    load_seed(16'h0000);
    run_phase(6, 1'b1, 1, "R10");            // zero seed acts as 0001
    load_seed(16'h8001);
    run_phase(6, 1'b0, 0, "R7");
    run_phase(6, 1'b1, 1, "R9");             // LFSR stepped during plain groups
    chk(multi_hs > 0, "R11", "edges with parallel handshakes", multi_hs, 1);
    finish_run();
  end
endmodule